// File: doc/BRIEF.md
# Reset Pulse and Power Mode Controller

This block holds the power state of a low-power supervisor. It has two modes, standby and run. It drives two outputs: an active-high enable for an external regulator that powers a microcontroller, and a reset pulse to that microcontroller. Wake and fault events arrive as single-cycle strobes. Which events may start a reset pulse depends on the current mode. In standby, the events that count are:

- a change on the data inputs,
- an impedance detection,
- an alarm,
- a device reset,
- an oscillator fault.

In run mode, the events that count are:

- a watchdog failure,
- an oscillator fault,
- a missed bus read,
- the external reset request.

A pulse lasts a selectable number of millisecond ticks. Every pulse also sends a one-cycle strobe to clear the bus interface. After a pulse starts, the maskable wake inputs stay blocked until software re-enables them.

Software drives the block through a control write strobe with a 5-bit data word. The word can request standby, set the regulator enable directly while in run mode, re-enable the blocked inputs and choose the pulse width. Two fault cases hand the system back to standby with the regulator switched off: a run of five watchdog failures in a row, and a missed bus read.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the block is in standby with `on_off`=0, `reset_pulse`=0, `bus_reset`=0 and `inputs_enabled`=1. The pulse width select is 2'b11.
- R2: The pulse width select `ctl_wdata[4:3]` chooses the pulse length in `ms_tick` pulses: 00 gives 1, 01 gives 5, 10 gives 10 and 11 gives 20. `reset_pulse` stays high for exactly that many ticks, counted from the trigger.
- R3: In standby, each of the following events moves the block to run with `on_off`=1 and starts a pulse in the next cycle:
  - `ev_osc_fault`, at any time;
  - `ev_input_chg`, `ev_impedance`, `ev_alarm` or `ev_dev_reset`, when `inputs_enabled`=1.
- R4: In run mode, `ev_input_chg`, `ev_impedance`, `ev_alarm` and `ev_dev_reset` start no pulse. `ev_wd_fail`, `ev_osc_fault`, `ev_missed_read` and `ev_ext_reset` each start a pulse. A pulse that leaves the block in run sets `on_off`=1.
- R5: Every pulse trigger clears `inputs_enabled`. While it is clear, the maskable events have no effect in standby. A control write with `ctl_wdata[2]`=1 sets it again.
- R6: In run mode, the fifth `ev_wd_fail` in a row moves the block to standby with `on_off`=0, and a pulse is still issued. That fifth failure resets the failure count. `ev_wd_ok` also clears the count, so four more failures afterwards keep the block in run.
- R7: In run mode, `ev_missed_read` moves the block to standby with `on_off`=0, and a pulse is still issued.
- R8: A control write in run mode behaves as follows:
  - with `ctl_wdata[0]`=1, it enters standby with `on_off`=0;
  - with `ctl_wdata[0]`=0, it copies `ctl_wdata[1]` to `on_off`.
  In standby, `ctl_wdata[1]` has no effect, and the block never has `on_off`=1 in standby.
- R9: In standby, `ev_wd_fail` has no effect. It starts no pulse and does not change the mode.
- R10: A trigger during a pulse restarts the width count. The pulse then ends the full selected width after the last trigger.
- R11: `bus_reset` is high for exactly the one cycle after each trigger, including restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond timebase strobe |
| ev_input_chg | input | 1 | Data input change strobe (maskable) |
| ev_impedance | input | 1 | Impedance detection strobe (maskable) |
| ev_alarm | input | 1 | Alarm strobe (maskable) |
| ev_dev_reset | input | 1 | Device reset strobe (maskable) |
| ev_osc_fault | input | 1 | Oscillator fault strobe |
| ev_wd_fail | input | 1 | Failed watchdog trigger sequence strobe |
| ev_wd_ok | input | 1 | Successful watchdog trigger strobe |
| ev_missed_read | input | 1 | Missed bus read strobe |
| ev_ext_reset | input | 1 | External reset request strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | [0] standby, [1] on/off value, [2] re-enable inputs, [4:3] width select |
| on_off | output | 1 | Regulator enable, high = on |
| reset_pulse | output | 1 | Reset pulse to the microcontroller |
| bus_reset | output | 1 | One-cycle bus interface reset strobe |
| inputs_enabled | output | 1 | Maskable wake inputs are accepted |
| mode_run | output | 1 | High in run mode |

## Verification
The hardest cases to reach are the watchdog count boundaries and the restart of a pulse partway through its count. The stimulus produces several consecutive failures in run mode, then clears the count, then counts up to the fifth failure again. For the restart case, the bench counts ticks under a running pulse and fires a second trigger after exactly three ticks. The expected total length then shows whether the counter reloaded. Masked-input cases are reached by leaving inputs blocked after a forced return to standby. Ungated oscillator faults are then used to show that only the maskable events are suppressed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic {MODE_STANDBY = 1'b0, MODE_RUN = 1'b1} mode_e;

  localparam int CTL_W      = 5;
  localparam int CTL_STBY   = 0;
  localparam int CTL_ONOFF  = 1;
  localparam int CTL_ENA    = 2;
  localparam int CTL_SEL_LO = 3;
  localparam int SEL_W      = 2;
  localparam logic [SEL_W-1:0] SEL_DEFAULT = 2'b11;
endpackage

// File: rtl/pmc_pulse_timer.sv
module pmc_pulse_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      pulse  <= 1'b0;
    end else if (start) begin
      remain <= width;
      pulse  <= 1'b1;
    end else if (pulse && ms_tick) begin
      if (remain <= CNT_W'(1)) begin
        remain <= '0;
        pulse  <= 1'b0;
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pmc_wd_counter.sv
module pmc_wd_counter #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic fail,
  input  logic ok,
  output logic limit_hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] fails;

  assign limit_hit = enable && fail && (fails == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fails <= '0;
    end else if (fail) begin
      fails <= limit_hit ? '0 : fails + CW'(1);
    end else if (ok) begin
      fails <= '0;
    end
  end
endmodule

// File: rtl/pmc_wake_filter.sv
module pmc_wake_filter (
  input  logic run,
  input  logic in_en,
  input  logic ev_input_chg,
  input  logic ev_impedance,
  input  logic ev_alarm,
  input  logic ev_dev_reset,
  input  logic ev_osc_fault,
  input  logic ev_wd_fail,
  input  logic ev_missed_read,
  input  logic ev_ext_reset,
  input  logic wd_limit,
  output logic wake,
  output logic run_trig,
  output logic shutdown
);
  logic maskable;

  always_comb begin
    maskable = in_en && (ev_input_chg || ev_impedance || ev_alarm || ev_dev_reset);
    wake     = !run && (maskable || ev_osc_fault);
    run_trig = run && (ev_wd_fail || ev_osc_fault || ev_missed_read || ev_ext_reset);
    shutdown = run && (ev_missed_read || wd_limit);
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int WIDTH0   = 1,
  parameter int WIDTH1   = 5,
  parameter int WIDTH2   = 10,
  parameter int WIDTH3   = 20,
  parameter int WD_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             ev_input_chg,
  input  logic             ev_impedance,
  input  logic             ev_alarm,
  input  logic             ev_dev_reset,
  input  logic             ev_osc_fault,
  input  logic             ev_wd_fail,
  input  logic             ev_wd_ok,
  input  logic             ev_missed_read,
  input  logic             ev_ext_reset,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             on_off,
  output logic             reset_pulse,
  output logic             bus_reset,
  output logic             inputs_enabled,
  output logic             mode_run
);
  localparam int CNT_W = $clog2(WIDTH3 + 1);

  mode_e            mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] width;
  logic             wake, run_trig, shutdown, trigger, wd_limit;
  logic             run;

  assign run      = (mode_q == MODE_RUN);
  assign mode_run = run;
  assign trigger  = wake || run_trig;

  always_comb begin
    case (sel_q)
      2'b00:   width = CNT_W'(WIDTH0);
      2'b01:   width = CNT_W'(WIDTH1);
      2'b10:   width = CNT_W'(WIDTH2);
      default: width = CNT_W'(WIDTH3);
    endcase
  end

  pmc_wake_filter i_filter (
    .run(run), .in_en(inputs_enabled),
    .ev_input_chg(ev_input_chg), .ev_impedance(ev_impedance),
    .ev_alarm(ev_alarm), .ev_dev_reset(ev_dev_reset),
    .ev_osc_fault(ev_osc_fault), .ev_wd_fail(ev_wd_fail),
    .ev_missed_read(ev_missed_read), .ev_ext_reset(ev_ext_reset),
    .wd_limit(wd_limit),
    .wake(wake), .run_trig(run_trig), .shutdown(shutdown)
  );

  pmc_wd_counter #(.LIMIT(WD_LIMIT)) i_wd (
    .clk(clk), .rst(rst), .enable(run),
    .fail(ev_wd_fail), .ok(ev_wd_ok), .limit_hit(wd_limit)
  );

  pmc_pulse_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .start(trigger), .width(width), .pulse(reset_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q         <= MODE_STANDBY;
      on_off         <= 1'b0;
      inputs_enabled <= 1'b1;
      sel_q          <= SEL_DEFAULT;
      bus_reset      <= 1'b0;
    end else begin
      bus_reset <= trigger;

      if (trigger)
        inputs_enabled <= 1'b0;
      else if (ctl_wr && ctl_wdata[CTL_ENA])
        inputs_enabled <= 1'b1;

      if (ctl_wr)
        sel_q <= ctl_wdata[CTL_SEL_LO +: SEL_W];

      if (!run) begin
        if (wake) begin
          mode_q <= MODE_RUN;
          on_off <= 1'b1;
        end
      end else if (shutdown) begin
        mode_q <= MODE_STANDBY;
        on_off <= 1'b0;
      end else if (run_trig) begin
        on_off <= 1'b1;
      end else if (ctl_wr) begin
        if (ctl_wdata[CTL_STBY]) begin
          mode_q <= MODE_STANDBY;
          on_off <= 1'b0;
        end else begin
          on_off <= ctl_wdata[CTL_ONOFF];
        end
      end
    end
  end
endmodule

// File: rtl/pmc_checks.sv
module pmc_checks (
  input logic clk,
  input logic rst,
  input logic ev_wd_fail,
  input logic ev_osc_fault,
  input logic ev_missed_read,
  input logic ev_ext_reset,
  input logic on_off,
  input logic reset_pulse,
  input logic bus_reset,
  input logic inputs_enabled,
  input logic mode_run
);
  assert_standby_off_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_run |-> !on_off);

  assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_run) |-> (reset_pulse && bus_reset && on_off));

  assert_strobe_in_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> reset_pulse);

  assert_trigger_masks_R5: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> !inputs_enabled);

  assert_missed_read_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_run && ev_missed_read) |=> (!mode_run && !on_off && bus_reset));

  assert_run_ignores_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_run && !(ev_wd_fail || ev_osc_fault || ev_missed_read || ev_ext_reset))
      |=> !bus_reset);
endmodule

bind pwr_mode_ctl pmc_checks i_pmc_checks (
  .clk(clk), .rst(rst),
  .ev_wd_fail(ev_wd_fail), .ev_osc_fault(ev_osc_fault),
  .ev_missed_read(ev_missed_read), .ev_ext_reset(ev_ext_reset),
  .on_off(on_off), .reset_pulse(reset_pulse), .bus_reset(bus_reset),
  .inputs_enabled(inputs_enabled), .mode_run(mode_run)
);

// File: tb/test_pwr_mode_ctl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctl;
  logic clk = 0, rst = 1, ms_tick = 0;
  logic ev_input_chg = 0, ev_impedance = 0, ev_alarm = 0, ev_dev_reset = 0;
  logic ev_osc_fault = 0, ev_wd_fail = 0, ev_wd_ok = 0, ev_missed_read = 0, ev_ext_reset = 0;
  logic ctl_wr = 0;
  logic [4:0] ctl_wdata = '0;
  logic on_off, reset_pulse, bus_reset, inputs_enabled, mode_run;

  int tests = 0, fails = 0, cyc = 0, tick_div = 0;
  bit finished = 0;

  typedef struct { int due; string tag; logic [4:0] exp; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .ev_input_chg(ev_input_chg), .ev_impedance(ev_impedance),
    .ev_alarm(ev_alarm), .ev_dev_reset(ev_dev_reset),
    .ev_osc_fault(ev_osc_fault), .ev_wd_fail(ev_wd_fail), .ev_wd_ok(ev_wd_ok),
    .ev_missed_read(ev_missed_read), .ev_ext_reset(ev_ext_reset),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .on_off(on_off), .reset_pulse(reset_pulse), .bus_reset(bus_reset),
    .inputs_enabled(inputs_enabled), .mode_run(mode_run)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin tick_div <= 0; ms_tick <= 0; end
    else begin
      tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
      ms_tick  <= (tick_div == 3);
    end
  end

  // monitor: compare {run,on_off,pulse,in_en,bus_reset}
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [4:0] act;
      it  = sb.pop_front();
      act = {mode_run, on_off, reset_pulse, inputs_enabled, bus_reset};
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_st(string tag, logic r, logic o, logic p, logic e, logic b);
    item_t it;
    it.due = cyc + 1; it.tag = tag; it.exp = {r, o, p, e, b};
    sb.push_back(it);
  endtask

  task automatic check_val(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_ev(int which, logic v);
    case (which)
      0: ev_input_chg = v;  1: ev_impedance = v;  2: ev_alarm = v;
      3: ev_dev_reset = v;  4: ev_osc_fault = v;  5: ev_wd_fail = v;
      6: ev_wd_ok = v;      7: ev_missed_read = v; 8: ev_ext_reset = v;
      default: ;
    endcase
  endtask

  // fire strobe at a negedge; caller pushes expectations before step
  task automatic fire(int which);
    set_ev(which, 1'b1);
  endtask

  task automatic step();
    @(negedge clk);
    for (int i = 0; i < 9; i++) set_ev(i, 1'b0);
    ctl_wr = 0;
  endtask

  task automatic ctl(logic [4:0] d);
    ctl_wr = 1; ctl_wdata = d;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (reset_pulse && g < 1000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  // count ticks while pulse high; called at the negedge right after trigger
  task automatic measure(string tag, int exp);
    int n = 0, g = 0;
    while (reset_pulse && g < 2000) begin
      if (ms_tick) n++;
      @(negedge clk); g++;
    end
    check_val(tag, n, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    expect_st("R1 reset state", 0, 0, 0, 1, 0);
    step();
    step();

    // R9: watchdog failure ignored in standby
    fire(5); expect_st("R9 wd_fail in standby", 0, 0, 0, 1, 0); step();
    step();

    // R3: input change wakes; R11 strobe; R5 inputs masked
    fire(0); expect_st("R3 wake by input change", 1, 1, 1, 0, 1); step();
    expect_st("R11 bus_reset one cycle", 1, 1, 1, 0, 0);
    measure("R2 default width 20 (R1)", 20);
    step();

    // R4: alarm ignored in run
    fire(2); expect_st("R4 alarm ignored in run", 1, 1, 0, 0, 0); step();
    step();

    // R8: on_off write in run, select width 00
    ctl(5'b00_0_0_0); expect_st("R8 on_off cleared in run", 1, 0, 0, 0, 0); step();
    step();
    fire(8); expect_st("R4 ext reset pulse sets on_off", 1, 1, 1, 0, 1); step();
    measure("R2 width sel 00 -> 1", 1);
    step();

    // R8: standby request, then on_off write ignored in standby
    ctl(5'b00_0_0_1); expect_st("R8 standby request", 0, 0, 0, 0, 0); step();
    step();
    ctl(5'b00_0_1_0); expect_st("R8 on_off ignored in standby", 0, 0, 0, 0, 0); step();
    step();
    // R5: masked inputs ignored
    fire(0); expect_st("R5 input change masked", 0, 0, 0, 0, 0); step();
    fire(3); expect_st("R5 device reset masked", 0, 0, 0, 0, 0); step();
    ctl(5'b01_1_0_0); expect_st("R5 re-enable inputs", 0, 0, 0, 1, 0); step();
    step();
    fire(2); expect_st("R3 wake by alarm", 1, 1, 1, 0, 1); step();
    measure("R2 width sel 01 -> 5", 5);
    step();

    // R10: restart during pulse, width 10
    ctl(5'b10_0_1_0); expect_st("R8 on_off set in run", 1, 1, 0, 0, 0); step();
    step();
    fire(4); expect_st("R10 first trigger", 1, 1, 1, 0, 1); step();
    n = 0;
    while (n < 3) begin if (ms_tick) n++; @(negedge clk); end
    fire(4); expect_st("R10 restart strobe (R11)", 1, 1, 1, 0, 1); step();
    measure("R10 pulse after restart", 10);
    step();

    // R6: four failures stay in run, ok clears, then five shut down
    for (int i = 0; i < 4; i++) begin
      fire(5); expect_st("R6 failure keeps run", 1, 1, 1, 0, 1); step();
    end
    fire(6); expect_st("R6 wd ok", 1, 1, 1, 0, 0); step();
    for (int i = 0; i < 4; i++) begin
      fire(5); expect_st("R6 count cleared by ok", 1, 1, 1, 0, 1); step();
    end
    fire(5); expect_st("R6 fifth failure -> standby", 0, 0, 1, 0, 1); step();
    wait_idle();

    // R3: oscillator fault wakes even while inputs masked
    fire(4); expect_st("R3 osc fault wakes masked", 1, 1, 1, 0, 1); step();
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      fire(5); expect_st("R6 counter reset at limit", 1, 1, 1, 0, 1); step();
    end
    wait_idle();
    check_val("R6 still run after 4 failures", int'(mode_run), 1);

    // R7: missed read
    fire(7); expect_st("R7 missed read -> standby", 0, 0, 1, 0, 1); step();
    wait_idle();
    fire(1); expect_st("R5 impedance masked", 0, 0, 0, 0, 0); step();
    step();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule